// File: doc/BRIEF.md
# PCI I/O Window Base Register

This block is the configuration-space slice of a PCI function that owns one I/O-space base address register. Configuration software writes the base one byte at a time and reads it back the same way. The block compares each incoming I/O address with the stored base and raises a hit when the address falls inside the 256-byte window.

The lowest byte of the register is fixed and tells software that the register describes I/O space. Every address bit above the window size can be written, including the top sixteen. A sizing probe with all ones therefore returns all ones in bits [31:8], not a 16-bit result. The hit output is gated by the command-register I/O enable, which comes in as an input. The hit output is also gated by a nonzero base. This stops an unprogrammed function from claiming the bottom of I/O space.

The window size (`WIN_BITS`) and the configuration offset of the register (`CFG_OFF`) are parameters. With the defaults, the register sits at offsets 0x18 to 0x1B and the window is 0x100 bytes long.

Top module: `io_bar_decode`

## Requirements
- R1: Reset clears the base. After reset the four bytes read 0x01, 0x00, 0x00, 0x00 (word 0x00000001), and io_hit is low.
- R2: A read of offset 0x18 always returns 0x01, where bit 0 set marks I/O space. Writes to offset 0x18 change nothing.
- R3: A write to offset 0x19 stores base bits [15:8], and a read of 0x19 returns them.
- R4: Writes to offsets 0x1A and 0x1B store base bits [23:16] and [31:24], and reads return them.
- R5: After 0xFF has been written to all four offsets, the word reads 0xFFFFFF01. Its address field, bits [31:8], is 0xFFFFFF00.
- R6: A byte write changes only its own byte lane, and the other three lanes keep their values.
- R7: io_hit is high when io_en is high, the base is nonzero and io_addr[31:8] equals base bits [31:8]. Addresses one past either end of the window give no hit.
- R8: io_hit is low whenever io_en is low, whatever the address is.
- R9: While the base is zero, io_hit stays low even when io_en is high and io_addr lies in the zero window.
- R10: Writes to offsets outside 0x18–0x1B leave the register unchanged. Reads of those offsets return 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_wr | input | 1 | Configuration byte write strobe |
| cfg_addr | input | 8 | Configuration byte offset for reads and writes |
| cfg_wdata | input | 8 | Configuration write byte |
| cfg_rdata | output | 8 | Configuration read byte, combinational from cfg_addr |
| io_en | input | 1 | I/O space enable from the command register |
| io_addr | input | 32 | Incoming I/O address |
| io_hit | output | 1 | Address lies in the decoded window |

## Verification
The bench builds the block with its defaults, WIN_BITS = 8 and CFG_OFF = 0x18. In this configuration the whole lowest byte is the fixed I/O indicator, so the fixed-lane and sizing results can be compared byte for byte with the requirements. A 256-byte window lets the boundary cases be hit exactly: the last byte inside the window, and the first byte past each end. Offsets 0x17 and 0x1C sit right next to the register and show that decoding does not leak into neighbouring configuration bytes.

// File: rtl/io_bar_decode.sv
module io_bar_decode #(
  parameter int unsigned WIN_BITS = 8,
  parameter logic [7:0]  CFG_OFF  = 8'h18
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cfg_wr,
  input  logic [7:0]  cfg_addr,
  input  logic [7:0]  cfg_wdata,
  output logic [7:0]  cfg_rdata,
  input  logic        io_en,
  input  logic [31:0] io_addr,
  output logic        io_hit
);
  localparam logic [31:0] WMASK    = ~((32'd1 << WIN_BITS) - 32'd1);
  localparam logic [31:0] IO_FLAG  = 32'h0000_0001;

  logic [31:0] base_q;
  logic        sel;
  logic [31:0] word_rd;

  assign sel     = (cfg_addr[7:2] == CFG_OFF[7:2]);
  assign word_rd = base_q | IO_FLAG;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      base_q <= '0;
    end else if (cfg_wr && sel) begin
      for (int ln = 0; ln < 4; ln++) begin
        if (cfg_addr[1:0] == ln[1:0])
          base_q[8*ln +: 8] <= cfg_wdata & WMASK[8*ln +: 8];
      end
    end
  end

  always_comb begin
    cfg_rdata = 8'h00;
    if (sel) begin
      case (cfg_addr[1:0])
        2'd0:    cfg_rdata = word_rd[7:0];
        2'd1:    cfg_rdata = word_rd[15:8];
        2'd2:    cfg_rdata = word_rd[23:16];
        default: cfg_rdata = word_rd[31:24];
      endcase
    end
  end

  assign io_hit = io_en && (base_q != '0) && ((io_addr & WMASK) == base_q);
endmodule

// File: rtl/io_bar_decode_chk.sv
module io_bar_decode_chk #(
  parameter int unsigned WIN_BITS = 8,
  parameter logic [7:0]  CFG_OFF  = 8'h18
) (
  input logic        clk,
  input logic        rst_n,
  input logic        cfg_wr,
  input logic [7:0]  cfg_addr,
  input logic [7:0]  cfg_wdata,
  input logic [7:0]  cfg_rdata,
  input logic        io_en,
  input logic        io_hit,
  input logic [31:0] base_q
);
  localparam logic [31:0] WMASK = ~((32'd1 << WIN_BITS) - 32'd1);

  AST_LANE0_FIXED: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_addr == CFG_OFF) |-> (cfg_rdata == 8'h01)); // R2

  AST_LANE1_STORE: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_wr && cfg_addr == (CFG_OFF | 8'h01)) |=> (base_q[15:8] == ($past(cfg_wdata) & WMASK[15:8]))); // R3

  AST_LANE_ISOLATE: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_wr && cfg_addr == (CFG_OFF | 8'h02)) |=> (base_q[15:0] == $past(base_q[15:0]) && base_q[31:24] == $past(base_q[31:24]))); // R6

  AST_NO_EN_NO_HIT: assert property (@(posedge clk) disable iff (!rst_n)
    !io_en |-> !io_hit); // R8

  AST_ZERO_BASE_NO_HIT: assert property (@(posedge clk) disable iff (!rst_n)
    (base_q == 32'd0) |-> !io_hit); // R9

  AST_OUTSIDE_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_wr && cfg_addr[7:2] != CFG_OFF[7:2]) |=> $stable(base_q)); // R10
endmodule

bind io_bar_decode io_bar_decode_chk #(.WIN_BITS(WIN_BITS), .CFG_OFF(CFG_OFF)) u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_addr(cfg_addr),
  .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .io_en(io_en),
  .io_hit(io_hit), .base_q(base_q)
);

// File: tb/test_io_bar_decode.sv
`timescale 1ns/1ps
module test_io_bar_decode;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_wr = 1'b0;
  logic [7:0]  cfg_addr = 8'h00;
  logic [7:0]  cfg_wdata = 8'h00;
  logic [7:0]  cfg_rdata;
  logic        io_en = 1'b0;
  logic [31:0] io_addr = 32'h0;
  logic        io_hit;
  int          n_run = 0;
  int          n_fail = 0;
  bit          done = 1'b0;

  always #5 clk = ~clk;

  io_bar_decode i_io_bar_decode (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .io_en(io_en),
    .io_addr(io_addr), .io_hit(io_hit)
  );

  // {offset, data, expected word after the write}
  localparam int NV = 11;
  localparam logic [47:0] VEC [NV] = '{
    {8'h19, 8'h12, 32'h0000_1201},  // R3
    {8'h1A, 8'h34, 32'h0034_1201},  // R4
    {8'h1B, 8'h56, 32'h5634_1201},  // R4
    {8'h18, 8'hFF, 32'h5634_1201},  // R2
    {8'h1C, 8'hAA, 32'h5634_1201},  // R10
    {8'h17, 8'hBB, 32'h5634_1201},  // R10
    {8'h1A, 8'h00, 32'h5600_1201},  // R6
    {8'h18, 8'hFF, 32'h5600_1201},  // R5
    {8'h19, 8'hFF, 32'h5600_FF01},  // R5
    {8'h1A, 8'hFF, 32'h56FF_FF01},  // R5
    {8'h1B, 8'hFF, 32'hFFFF_FF01}   // R5
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %08h expected %08h", req, act, exp);
    end
  endtask

  task automatic cfg_write(input logic [7:0] off, input logic [7:0] d);
    @(negedge clk);
    cfg_wr = 1'b1; cfg_addr = off; cfg_wdata = d;
    @(negedge clk);
    cfg_wr = 1'b0;
  endtask

  task automatic read_word(output logic [31:0] w);
    for (int k = 0; k < 4; k++) begin
      cfg_addr = 8'h18 + 8'(k);
      #1;
      w[8*k +: 8] = cfg_rdata;
    end
  endtask

  task automatic hit_at(input logic en, input logic [31:0] a, output logic h);
    io_en = en; io_addr = a;
    #1;
    h = io_hit;
  endtask

  initial begin
    logic [31:0] w;
    logic h;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    read_word(w);
    check("R1 reset word", w, 32'h0000_0001);
    hit_at(1'b1, 32'h0000_0010, h);
    check("R1 reset hit", {31'd0, h}, 32'd0);

    for (int i = 0; i < NV; i++) begin
      cfg_write(VEC[i][47:40], VEC[i][39:32]);
      read_word(w);
      check($sformatf("table vector %0d (R2 R3 R4 R5 R6 R10)", i), w, VEC[i][31:0]);
    end

    cfg_addr = 8'h1C; #1;
    check("R10 outside read", {24'd0, cfg_rdata}, 32'd0);

    cfg_write(8'h19, 8'hA5);
    cfg_write(8'h1A, 8'h00);
    cfg_write(8'h1B, 8'hC0);
    hit_at(1'b1, 32'hC000_A5FF, h);
    check("R7 top of window", {31'd0, h}, 32'd1);
    hit_at(1'b1, 32'hC000_A500, h);
    check("R7 bottom of window", {31'd0, h}, 32'd1);
    hit_at(1'b1, 32'hC000_A600, h);
    check("R7 above window", {31'd0, h}, 32'd0);
    hit_at(1'b1, 32'hC000_A4FF, h);
    check("R7 below window", {31'd0, h}, 32'd0);
    hit_at(1'b0, 32'hC000_A510, h);
    check("R8 io_en low", {31'd0, h}, 32'd0);

    cfg_write(8'h19, 8'h00);
    cfg_write(8'h1B, 8'h00);
    hit_at(1'b1, 32'h0000_00FF, h);
    check("R9 zero base", {31'd0, h}, 32'd0);

    cfg_write(8'h1A, 8'h77);
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    read_word(w);
    check("R1 mid-run reset", w, 32'h0000_0001);

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule